// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory-mapped slave and watches its read-address, write-address, write-data, read-response and write-response channels. Every transaction ID owns one slot in a small reservation table. An exclusive read that obeys the size, length and alignment rules records its address, burst length and burst size in the slot for its ID. A later exclusive write with the same ID is checked against that slot. The write passes when the reservation is still intact and the address, length and size all match.

A passing write reaches memory with its byte strobes untouched, and its OKAY response is rewritten to EXOKAY. A failing exclusive write has its strobes forced to zero, so memory keeps its old contents, and its response stays OKAY. Any write that overlaps a reserved byte range cancels that reservation, whichever ID issued it. The monitor does not stall any channel. It only observes handshakes and rewrites the strobe and response fields as they pass through. It assumes that the write address of a burst is accepted no later than the first beat of its data, that W bursts follow write-address order, and that responses with one ID return in issue order.

Top module: `excl_monitor`

## Requirements
- R1: After reset no slot holds a reservation. An exclusive write (lock field 2'b01) issued before any exclusive read fails: its strobes are driven as zero and its response stays OKAY (2'b00).
- R2: An exclusive read that meets the rules of R5 installs a reservation for its ID. Its read response is rewritten from OKAY (2'b00) to EXOKAY (2'b01). A slave error response on that read is passed through unchanged.
- R3: An exclusive write with an intact reservation for its ID and the same address, burst length and burst size passes. Its strobes pass unchanged and its write response is rewritten from OKAY to EXOKAY.
- R4: An exclusive write fails when its ID has no reservation or when its address, length or size differs from the reservation. A failing write has all strobes of its burst forced to zero and its response left as OKAY.
- R5: An exclusive access is legal only when the beat count (length field + 1) is a power of two no greater than 16, the total bytes (beats << size) are at most 128, and the start address is a multiple of that total. An illegal exclusive read installs nothing and gets no EXOKAY. An illegal exclusive write fails.
- R6: At the write-address handshake, any write whose byte range overlaps a reservation cancels that reservation, for every ID. This covers normal writes and passing exclusive writes. A failing exclusive write cancels nothing.
- R7: A legal exclusive read with an ID that already holds a reservation replaces it. A write to the old range then no longer passes, and a write to the new range passes.
- R8: Reservations under different IDs on the same range are tracked independently. Normal reads never change any reservation.
- R9: Only the lock value 2'b01 is exclusive. The values 2'b00 (normal), 2'b10 (locked) and 2'b11 (reserved) are treated as normal accesses: reads reserve nothing, and writes clear overlapping reservations.
- R10: Response codes are OKAY=2'b00, EXOKAY=2'b01, SLVERR=2'b10 and DECERR=2'b11. Only OKAY is ever rewritten. Error responses pass through unchanged.
- R11: When a read-address and a write-address handshake happen in the same cycle, the write's clearing is applied first. A reservation installed by that read therefore survives the write.
- R12: The strobe gating of each W burst follows the order of write-address handshakes. This also holds when a beat arrives in the same cycle as its address or while several addresses are waiting for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Log2 bytes per read beat |
| ar_lock | input | 2 | Read access type |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | Log2 bytes per write beat |
| aw_lock | input | 2 | Write access type |
| w_valid | input | 1 | Write-data valid |
| w_ready | input | 1 | Write-data ready |
| w_last | input | 1 | Last beat of the W burst |
| w_strb_in | input | WSTRB_W | Byte strobes from the master |
| w_strb_out | output | WSTRB_W | Byte strobes to the memory |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | ID_W | Read-data ID |
| r_last | input | 1 | Last read beat |
| r_resp_in | input | 2 | Read response from the slave |
| r_resp_out | output | 2 | Read response to the master |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| b_id | input | ID_W | Write-response ID |
| b_resp_in | input | 2 | Write response from the slave |
| b_resp_out | output | 2 | Write response to the master |

## Verification
The directed cases set up reservation histories that the pass/fail verdict must tell apart. These are: an exact match against a stale reservation after a clearing write; a write whose length or address is off by one field; a reservation replaced by a second read; two IDs sharing one range; and a failing write that must leave the reservation in place. The rule checker is driven at its edges: 16 beats against 32, 128 bytes against 256, aligned against misaligned, and three beats as a non-power-of-two count. Two directed cases cover ordering: simultaneous read and write addresses, and two write addresses queued before their data. The random phase reuses each ID's last reservation often enough that passing writes occur alongside clearing traffic from other IDs. A bench model predicts every strobe and response.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        LK_NORMAL = 2'b00,
        LK_EXCL   = 2'b01,
        LK_LOCKED = 2'b10,
        LK_RSVD   = 2'b11
    } lock_e;

    localparam int unsigned MAX_EXCL_BEATS      = 16;
    localparam int unsigned MAX_EXCL_BYTES_LOG2 = 7;
    localparam int unsigned SPAN_BYTES_W        = 16;

    // Bytes covered by an incrementing burst.
    function automatic logic [SPAN_BYTES_W-1:0] burst_bytes(input logic [7:0] len,
                                                            input logic [2:0] size);
        logic [SPAN_BYTES_W-1:0] beats;
        beats = {{(SPAN_BYTES_W-8){1'b0}}, len} + 1'b1;
        return beats << size;
    endfunction

endpackage

// File: rtl/excl_rule_check.sv
module excl_rule_check
    import excl_mon_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        len,
    input  logic [2:0]        size,
    output logic              ok
);
    localparam int unsigned LOW_W = MAX_EXCL_BYTES_LOG2;

    logic [8:0]       beats;
    logic             beats_pow2;
    logic [2:0]       beats_lg;
    logic [3:0]       total_lg;
    logic [11:0]      span_m1;
    logic [LOW_W-1:0] low_mask;

    always_comb begin
        beats      = {1'b0, len} + 9'd1;
        beats_pow2 = (beats & (beats - 9'd1)) == 9'd0;
        beats_lg   = '0;
        for (int i = 0; i <= 4; i++) begin
            if (beats == 9'(1 << i)) beats_lg = 3'(i);
        end
        total_lg = {1'b0, size} + {1'b0, beats_lg};
        span_m1  = (12'd1 << total_lg) - 12'd1;
        low_mask = span_m1[LOW_W-1:0];
        ok = beats_pow2
          && (beats <= 9'(MAX_EXCL_BEATS))
          && (total_lg <= 4'(MAX_EXCL_BYTES_LOG2))
          && ((addr[LOW_W-1:0] & low_mask) == '0);
    end

    always_comb begin
        if (ok) begin
            assert_legal_beats_R5 : assert (len < 8'(MAX_EXCL_BEATS));
        end
    end

endmodule

// File: rtl/excl_resv_table.sv
module excl_resv_table
    import excl_mon_pkg::*;
#(
    parameter int unsigned ID_W   = 2,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_take,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [7:0]        ar_len,
    input  logic [2:0]        ar_size,
    input  logic              aw_fire,
    input  logic              aw_excl,
    input  logic              aw_legal,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [7:0]        aw_len,
    input  logic [2:0]        aw_size,
    input  logic              r_done,
    input  logic [ID_W-1:0]   r_id,
    input  logic              b_fire,
    input  logic [ID_W-1:0]   b_id,
    output logic              aw_pass,
    output logic              rd_exok,
    output logic              wr_exok
);
    localparam int unsigned NSLOT  = 1 << ID_W;
    localparam int unsigned SPAN_W = ADDR_W + 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        len;
        logic [2:0]        size;
    } entry_t;

    typedef struct packed {
        entry_t [NSLOT-1:0] ent;
        logic   [NSLOT-1:0] rd_pend;
        logic   [NSLOT-1:0] wr_pass;
    } table_t;

    table_t st_d, st_q;

    logic [NSLOT-1:0]  ovl;
    logic [NSLOT-1:0]  resv_vld;
    logic [SPAN_W-1:0] w_lo, w_hi;
    logic              aw_match;
    logic              aw_clears;

    assign w_lo = {1'b0, aw_addr};
    assign w_hi = w_lo + SPAN_W'(burst_bytes(aw_len, aw_size));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [SPAN_W-1:0] r_lo, r_hi;
        assign r_lo        = {1'b0, st_q.ent[g].addr};
        assign r_hi        = r_lo + SPAN_W'(burst_bytes(st_q.ent[g].len, st_q.ent[g].size));
        assign ovl[g]      = st_q.ent[g].vld && (w_lo < r_hi) && (r_lo < w_hi);
        assign resv_vld[g] = st_q.ent[g].vld;
    end

    always_comb begin
        aw_match = st_q.ent[aw_id].vld
                && (st_q.ent[aw_id].addr == aw_addr)
                && (st_q.ent[aw_id].len  == aw_len)
                && (st_q.ent[aw_id].size == aw_size);
        aw_pass   = aw_excl && aw_legal && aw_match;
        aw_clears = aw_fire && (!aw_excl || aw_pass);
        rd_exok   = st_q.rd_pend[r_id];
        wr_exok   = st_q.wr_pass[b_id];
    end

    always_comb begin
        st_d = st_q;
        // Write clearing is applied before a same-cycle reservation.
        for (int s = 0; s < NSLOT; s++) begin
            if (aw_clears && ovl[s]) st_d.ent[s].vld = 1'b0;
        end
        if (ar_take) begin
            st_d.ent[ar_id].vld  = 1'b1;
            st_d.ent[ar_id].addr = ar_addr;
            st_d.ent[ar_id].len  = ar_len;
            st_d.ent[ar_id].size = ar_size;
        end
        if (r_done)  st_d.rd_pend[r_id] = 1'b0;
        if (ar_take) st_d.rd_pend[ar_id] = 1'b1;
        if (b_fire)  st_d.wr_pass[b_id] = 1'b0;
        if (aw_fire && aw_pass) st_d.wr_pass[aw_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pass_clears_own_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (aw_fire && aw_pass && !(ar_take && ar_id == aw_id)) |=> !resv_vld[$past(aw_id)]);

    assert_read_installs_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        ar_take |=> resv_vld[$past(ar_id)]);

    assert_fail_keeps_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (aw_fire && aw_excl && !aw_pass && !ar_take) |=> (resv_vld == $past(resv_vld)));

    assert_pass_needs_resv_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        aw_pass |-> resv_vld[aw_id]);

endmodule

// File: rtl/excl_kill_fifo.sv
module excl_kill_fifo #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_kill,
    input  logic pop,
    output logic kill_now
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0] kill;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  empty, full;

    assign empty = st_q.cnt == '0;
    assign full  = st_q.cnt == CNT_W'(DEPTH);

    always_comb begin
        // An empty queue bypasses the verdict pushed in this cycle.
        kill_now = empty ? (push && push_kill) : st_q.kill[st_q.rd];
        st_d = st_q;
        if (!(empty && push && pop)) begin
            if (push) begin
                st_d.kill[st_q.wr] = push_kill;
                st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            end
            if (pop && !empty) begin
                st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop && !empty);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));

    assert_no_underflow_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty && !push));

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int unsigned ID_W     = 2,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WSTRB_W  = 8,
    parameter int unsigned WQ_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ar_valid,
    input  logic               ar_ready,
    input  logic [ID_W-1:0]    ar_id,
    input  logic [ADDR_W-1:0]  ar_addr,
    input  logic [7:0]         ar_len,
    input  logic [2:0]         ar_size,
    input  logic [1:0]         ar_lock,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic [ID_W-1:0]    aw_id,
    input  logic [ADDR_W-1:0]  aw_addr,
    input  logic [7:0]         aw_len,
    input  logic [2:0]         aw_size,
    input  logic [1:0]         aw_lock,
    input  logic               w_valid,
    input  logic               w_ready,
    input  logic               w_last,
    input  logic [WSTRB_W-1:0] w_strb_in,
    output logic [WSTRB_W-1:0] w_strb_out,
    input  logic               r_valid,
    input  logic               r_ready,
    input  logic [ID_W-1:0]    r_id,
    input  logic               r_last,
    input  logic [1:0]         r_resp_in,
    output logic [1:0]         r_resp_out,
    input  logic               b_valid,
    input  logic               b_ready,
    input  logic [ID_W-1:0]    b_id,
    input  logic [1:0]         b_resp_in,
    output logic [1:0]         b_resp_out
);
    logic ar_fire, aw_fire, w_fire, r_fire, b_fire;
    logic ar_excl, aw_excl, ar_legal, aw_legal, ar_take;
    logic aw_pass, rd_exok, wr_exok, kill_now;

    assign ar_fire = ar_valid && ar_ready;
    assign aw_fire = aw_valid && aw_ready;
    assign w_fire  = w_valid && w_ready;
    assign r_fire  = r_valid && r_ready;
    assign b_fire  = b_valid && b_ready;
    assign ar_excl = ar_lock == LK_EXCL;
    assign aw_excl = aw_lock == LK_EXCL;
    assign ar_take = ar_fire && ar_excl && ar_legal;

    excl_rule_check #(.ADDR_W(ADDR_W)) u_ar_rules (
        .addr(ar_addr), .len(ar_len), .size(ar_size), .ok(ar_legal)
    );

    excl_rule_check #(.ADDR_W(ADDR_W)) u_aw_rules (
        .addr(aw_addr), .len(aw_len), .size(aw_size), .ok(aw_legal)
    );

    excl_resv_table #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_take  (ar_take),
        .ar_id    (ar_id),
        .ar_addr  (ar_addr),
        .ar_len   (ar_len),
        .ar_size  (ar_size),
        .aw_fire  (aw_fire),
        .aw_excl  (aw_excl),
        .aw_legal (aw_legal),
        .aw_id    (aw_id),
        .aw_addr  (aw_addr),
        .aw_len   (aw_len),
        .aw_size  (aw_size),
        .r_done   (r_fire && r_last),
        .r_id     (r_id),
        .b_fire   (b_fire),
        .b_id     (b_id),
        .aw_pass  (aw_pass),
        .rd_exok  (rd_exok),
        .wr_exok  (wr_exok)
    );

    excl_kill_fifo #(.DEPTH(WQ_DEPTH)) u_kill_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (aw_fire),
        .push_kill (aw_excl && !aw_pass),
        .pop       (w_fire && w_last),
        .kill_now  (kill_now)
    );

    always_comb begin
        w_strb_out = kill_now ? '0 : w_strb_in;
        r_resp_out = (r_resp_in == RSP_OKAY && rd_exok) ? RSP_EXOKAY : r_resp_in;
        b_resp_out = (b_resp_in == RSP_OKAY && wr_exok) ? RSP_EXOKAY : b_resp_in;
    end

    assert_r_exok_from_okay_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_resp_out == RSP_EXOKAY) |-> (r_resp_in == RSP_OKAY));

    assert_b_exok_from_okay_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_resp_out == RSP_EXOKAY) |-> (b_resp_in == RSP_OKAY));

    assert_errors_pass_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_resp_in[1]) |-> (b_resp_out == b_resp_in));

    assert_strb_all_or_none_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (w_strb_out == w_strb_in || w_strb_out == '0));

endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
    logic [1:0]  ar_id = 0, aw_id = 0, r_id = 0, b_id = 0;
    logic [31:0] ar_addr = 0, aw_addr = 0;
    logic [7:0]  ar_len = 0, aw_len = 0;
    logic [2:0]  ar_size = 0, aw_size = 0;
    logic [1:0]  ar_lock = 0, aw_lock = 0;
    logic        w_valid = 0, w_ready = 0, w_last = 0;
    logic [7:0]  w_strb_in = 0, w_strb_out;
    logic        r_valid = 0, r_ready = 0, r_last = 0;
    logic [1:0]  r_resp_in = 0, r_resp_out, b_resp_in = 0, b_resp_out;
    logic        b_valid = 0, b_ready = 0;

    int total = 0, bad = 0;

    bit          m_vld [4];
    logic [31:0] m_addr [4];
    int          m_len [4], m_size [4];

    always #(CLK_NS/2) clk = ~clk;

    excl_monitor uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic bit m_rules(input logic [31:0] addr, input int len, input int size);
        int beats = len + 1;
        int bytes = beats * (1 << size);
        return beats <= 16 && (beats & (beats - 1)) == 0 && bytes <= 128 && (addr % bytes) == 0;
    endfunction

    function automatic void m_clear(input logic [31:0] addr, input int len, input int size);
        longint wl = addr;
        longint wh = wl + (len + 1) * (1 << size);
        for (int s = 0; s < 4; s++) begin
            longint rl = m_addr[s];
            longint rh = rl + (m_len[s] + 1) * (1 << m_size[s]);
            if (m_vld[s] && wl < rh && rl < wh) m_vld[s] = 0;
        end
    endfunction

    function automatic bit m_pass(input int id, input logic [31:0] addr, input int len,
                                  input int size, input logic [1:0] lock);
        return lock == 2'b01 && m_rules(addr, len, size) && m_vld[id] && m_addr[id] == addr
            && m_len[id] == len && m_size[id] == size;
    endfunction

    task automatic ar_op(input int id, input logic [31:0] addr, input int len, input int size,
                         input logic [1:0] lock, input logic [1:0] rin, input string tag);
        bit take = lock == 2'b01 && m_rules(addr, len, size);
        @(negedge clk);
        ar_valid = 1; ar_ready = 1; ar_id = 2'(id); ar_addr = addr;
        ar_len = 8'(len); ar_size = 3'(size); ar_lock = lock;
        @(posedge clk); #1;
        ar_valid = 0;
        if (take) begin
            m_vld[id] = 1; m_addr[id] = addr; m_len[id] = len; m_size[id] = size;
        end
        @(negedge clk);
        r_valid = 1; r_ready = 1; r_last = 1; r_id = 2'(id); r_resp_in = rin;
        #2 chk(tag, 32'(r_resp_out), (take && rin == 2'b00) ? 32'd1 : 32'(rin), "read resp");
        @(posedge clk); #1;
        r_valid = 0;
    endtask

    task automatic aw_op(input int id, input logic [31:0] addr, input int len, input int size,
                         input logic [1:0] lock, input logic [1:0] bin, input bit w_late,
                         input string tag);
        bit excl = lock == 2'b01;
        bit pass = m_pass(id, addr, len, size, lock);
        logic [7:0] strb = 8'($urandom) | 8'h01;
        @(negedge clk);
        aw_valid = 1; aw_ready = 1; aw_id = 2'(id); aw_addr = addr;
        aw_len = 8'(len); aw_size = 3'(size); aw_lock = lock;
        if (!w_late) begin
            w_valid = 1; w_ready = 1; w_last = 1; w_strb_in = strb;
            #2 chk(tag, 32'(w_strb_out), (excl && !pass) ? 32'd0 : 32'(strb), "strobe");
        end
        @(posedge clk); #1;
        aw_valid = 0; w_valid = 0;
        if (!excl || pass) m_clear(addr, len, size);
        if (w_late) begin
            @(negedge clk);
            w_valid = 1; w_ready = 1; w_last = 1; w_strb_in = strb;
            #2 chk(tag, 32'(w_strb_out), (excl && !pass) ? 32'd0 : 32'(strb), "late strobe");
            @(posedge clk); #1;
            w_valid = 0;
        end
        @(negedge clk);
        b_valid = 1; b_ready = 1; b_id = 2'(id); b_resp_in = bin;
        #2 chk(tag, 32'(b_resp_out), (pass && bin == 2'b00) ? 32'd1 : 32'(bin), "write resp");
        @(posedge clk); #1;
        b_valid = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0005EED1));
        for (int s = 0; s < 4; s++) begin
            m_vld[s] = 0; m_addr[s] = 0; m_len[s] = 0; m_size[s] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: idle response after reset, then exclusive write with no reservation.
        @(negedge clk);
        r_valid = 1; r_resp_in = 2'b00; r_id = 2'd0;
        #2 chk("R1", 32'(r_resp_out), 32'd0, "reset read resp");
        @(posedge clk); #1 r_valid = 0;
        aw_op(0, 32'h100, 0, 2, 2'b01, 2'b00, 0, "R1");

        // R2 / R3 / R10: reservation, pass, then stale reuse fails.
        ar_op(1, 32'h200, 3, 2, 2'b01, 2'b00, "R2");
        ar_op(2, 32'h300, 0, 0, 2'b01, 2'b10, "R10");
        aw_op(1, 32'h200, 3, 2, 2'b01, 2'b00, 0, "R3");
        aw_op(1, 32'h200, 3, 2, 2'b01, 2'b00, 0, "R6");

        // R4: field mismatch fails and leaves the reservation.
        ar_op(1, 32'h200, 3, 2, 2'b01, 2'b00, "R2");
        aw_op(1, 32'h200, 1, 2, 2'b01, 2'b00, 0, "R4");
        aw_op(1, 32'h210, 3, 2, 2'b01, 2'b00, 0, "R4");
        aw_op(1, 32'h200, 3, 1, 2'b01, 2'b00, 0, "R4");
        aw_op(1, 32'h200, 3, 2, 2'b01, 2'b00, 0, "R6");

        // R5: rule boundaries.
        ar_op(0, 32'h104, 3, 2, 2'b01, 2'b00, "R5");
        ar_op(0, 32'h100, 2, 0, 2'b01, 2'b00, "R5");
        ar_op(0, 32'h100, 31, 0, 2'b01, 2'b00, "R5");
        ar_op(0, 32'h400, 15, 4, 2'b01, 2'b00, "R5");
        ar_op(0, 32'h440, 15, 3, 2'b01, 2'b00, "R5");
        ar_op(0, 32'h400, 15, 3, 2'b01, 2'b00, "R5");
        aw_op(0, 32'h400, 15, 3, 2'b01, 2'b10, 0, "R10");

        // R7: replacement by a new read on the same ID.
        ar_op(3, 32'h500, 0, 2, 2'b01, 2'b00, "R7");
        ar_op(3, 32'h600, 0, 2, 2'b01, 2'b00, "R7");
        aw_op(3, 32'h500, 0, 2, 2'b01, 2'b00, 0, "R7");
        aw_op(3, 32'h600, 0, 2, 2'b01, 2'b00, 0, "R7");

        // R8: two IDs on one range, normal read, unrelated write.
        ar_op(0, 32'h700, 1, 2, 2'b01, 2'b00, "R8");
        ar_op(2, 32'h700, 1, 2, 2'b01, 2'b00, "R8");
        ar_op(1, 32'h700, 1, 2, 2'b00, 2'b00, "R8");
        aw_op(1, 32'h800, 1, 2, 2'b00, 2'b00, 0, "R8");
        aw_op(2, 32'h700, 1, 2, 2'b01, 2'b00, 0, "R8");
        aw_op(0, 32'h700, 1, 2, 2'b01, 2'b00, 0, "R6");

        // R9: locked and reserved lock values act as normal accesses.
        ar_op(0, 32'h900, 0, 2, 2'b01, 2'b00, "R9");
        aw_op(3, 32'h902, 0, 0, 2'b10, 2'b00, 0, "R9");
        aw_op(0, 32'h900, 0, 2, 2'b01, 2'b00, 0, "R9");
        ar_op(0, 32'h900, 0, 2, 2'b01, 2'b00, "R9");
        aw_op(3, 32'h8FC, 1, 2, 2'b11, 2'b00, 1, "R9");
        aw_op(0, 32'h900, 0, 2, 2'b01, 2'b00, 0, "R9");
        ar_op(0, 32'h900, 0, 2, 2'b10, 2'b00, "R9");
        aw_op(0, 32'h900, 0, 2, 2'b01, 2'b00, 0, "R9");

        // R11: read and write addresses in one cycle.
        ar_op(0, 32'hA00, 0, 3, 2'b01, 2'b00, "R11");
        @(negedge clk);
        ar_valid = 1; ar_ready = 1; ar_id = 2'd1; ar_addr = 32'hA00;
        ar_len = 0; ar_size = 3; ar_lock = 2'b01;
        aw_valid = 1; aw_ready = 1; aw_id = 2'd2; aw_addr = 32'hA00;
        aw_len = 0; aw_size = 3; aw_lock = 2'b00;
        w_valid = 1; w_ready = 1; w_last = 1; w_strb_in = 8'hFF;
        #2 chk("R11", 32'(w_strb_out), 32'hFF, "normal strobe");
        @(posedge clk); #1;
        ar_valid = 0; aw_valid = 0; w_valid = 0;
        m_clear(32'hA00, 0, 3);
        m_vld[1] = 1; m_addr[1] = 32'hA00; m_len[1] = 0; m_size[1] = 3;
        @(negedge clk);
        r_valid = 1; r_ready = 1; r_last = 1; r_id = 2'd1; r_resp_in = 2'b00;
        b_valid = 1; b_ready = 1; b_id = 2'd2; b_resp_in = 2'b00;
        #2 chk("R11", 32'(r_resp_out), 32'd1, "read resp");
        chk("R11", 32'(b_resp_out), 32'd0, "write resp");
        @(posedge clk); #1;
        r_valid = 0; b_valid = 0;
        aw_op(1, 32'hA00, 0, 3, 2'b01, 2'b00, 0, "R11");
        aw_op(0, 32'hA00, 0, 3, 2'b01, 2'b00, 0, "R11");

        // R12: two addresses queued before their data.
        @(negedge clk);
        aw_valid = 1; aw_ready = 1; aw_id = 2'd3; aw_addr = 32'hC00;
        aw_len = 1; aw_size = 2; aw_lock = 2'b01;
        @(posedge clk); #1;
        @(negedge clk);
        aw_id = 2'd2; aw_addr = 32'hD00; aw_len = 0; aw_size = 2; aw_lock = 2'b00;
        @(posedge clk); #1;
        aw_valid = 0;
        @(negedge clk);
        w_valid = 1; w_ready = 1; w_last = 0; w_strb_in = 8'hFF;
        #2 chk("R12", 32'(w_strb_out), 32'd0, "first burst beat 0");
        @(posedge clk); #1;
        @(negedge clk);
        w_last = 1;
        #2 chk("R12", 32'(w_strb_out), 32'd0, "first burst last beat");
        @(posedge clk); #1;
        @(negedge clk);
        w_strb_in = 8'h3C;
        #2 chk("R12", 32'(w_strb_out), 32'h3C, "second burst");
        @(posedge clk); #1;
        w_valid = 0;

        // Random mix checked against the model.
        for (int n = 0; n < 400; n++) begin
            int op   = $urandom % 5;
            int id   = $urandom % 4;
            int lens [6] = '{0, 1, 3, 7, 15, 2};
            int len  = lens[$urandom % 6];
            int size = $urandom % 4;
            logic [31:0] addr = 32'h1000 + 32'(($urandom % 4) * 64) + 32'(($urandom % 3) * 8);
            logic [1:0]  rsp  = ($urandom % 8 == 0) ? 2'b10 : 2'b00;
            bit late = $urandom % 2;
            case (op)
                0: ar_op(id, addr, len, size, 2'b01, rsp, "R2");
                1: begin
                    if (m_vld[id]) begin
                        addr = m_addr[id]; len = m_len[id]; size = m_size[id];
                    end
                    aw_op(id, addr, len, size, 2'b01, rsp, late,
                          m_pass(id, addr, len, size, 2'b01) ? "R3" : "R4");
                end
                2: aw_op(id, addr, len, size, 2'(($urandom % 2) * 2), rsp, late, "R6");
                3: aw_op(id, addr, len, size, 2'b01, rsp, late, "R4");
                default: ar_op(id, addr, len, size, 2'b00, rsp, "R8");
            endcase
        end

        finish_run();
    end
endmodule